// File: doc/BRIEF.md
# Sequenced ADC Serial Interface Controller

This block is the host-side master for a multichannel 12-bit successive-approximation converter that talks over a 16-clock serial frame. For each accepted request it lowers chip select, sends a 16-bit control word most significant bit first on the data-in line, and at the same time collects the converter's 16-bit result word from the data-out line. All serial timing comes from the system clock through parameters: the serial clock half period, the chip-select setup before the first clock edge, the hold after the last clock edge, and the quiet gap that must pass before chip select may fall again.

The converter changes its output just after each serial clock falling edge and takes data-in on that same falling edge. The controller therefore changes data-in on rising edges and samples data-out on rising edges. The serial clock rests high whenever chip select is high. On the user side a valid/ready request carries the control word. When chip select rises, a one-cycle response strobe returns the received word together with a flag that says whether the result can be trusted.

The controller tracks the converter's power mode from the write-enabled control words it sends. A frame started while the converter is in a shutdown mode returns an untrusted result. After a control word brings the converter back to normal operation, results from frames started within the power-up window are also untrusted.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `adc_cs_n` is 1, `adc_sclk` is 1, `rsp_valid` is 0 and `req_ready` is 1.
- R2: Every frame holds `adc_cs_n` low for exactly 16 falling edges of `adc_sclk`. `adc_sclk` is high on every cycle in which `adc_cs_n` is high.
- R3: The control word appears on `adc_din` most significant bit first. `adc_din` changes only at rising edges of `adc_sclk` or while chip select is falling, so it is stable at every falling edge.
- R4: `adc_dout` is sampled at each of the 16 rising edges, and the first sample becomes bit 15 of `rsp_word`.
- R5: At least `SETUP_CYC` system cycles pass between the fall of `adc_cs_n` and the first falling edge of `adc_sclk`.
- R6: `adc_cs_n` rises only after the 16th rising edge, and at least `HOLD_CYC` cycles after it.
- R7: Once high, `adc_cs_n` stays high for at least `QUIET_CYC`+1 cycles. `req_ready` is 0 from acceptance until the quiet gap ends. A request presented earlier is held and not dropped.
- R8: `rsp_valid` is a one-cycle pulse in the cycle in which `adc_cs_n` rises.
- R9: The power mode takes effect only from a control word with bit 11 set, and is read from bits 5:4: 11 means normal, 10 means full shutdown, 01 means auto shutdown. A frame started while the recorded mode is not normal returns `rsp_ok`=0.
- R10: A write of normal mode made while the recorded mode is a shutdown mode starts a `PU_CYC`-cycle power-up window at its chip-select fall. Frames that start inside the window return `rsp_ok`=0. Frames that start in normal mode after the window return `rsp_ok`=1.
- R11: A control word with bit 11 clear leaves the recorded power mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_word | input | 16 | Control word to send |
| req_ready | output | 1 | Controller can accept a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_word | output | 16 | Word received from the converter |
| rsp_ok | output | 1 | Result is trusted (converter fully powered) |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_din | output | 1 | Serial control data to the converter |
| adc_dout | input | 1 | Serial result data from the converter |

## Verification
Back-to-back frames run with result words made of alternating bits, all ones, a single set LSB and a single set MSB, so that a reversed bit order, an off-by-one sample point or a lost edge each gives a different wrong word. The control sequence steps through normal, full shutdown, a no-write frame, a wake-up, a frame inside the power-up window, a frame after it, auto shutdown and a wake from auto shutdown. This separates a trust flag based on the mode from one based on the window. Each request is raised during the previous quiet gap, which shows whether a waiting request is held or shortens the gap.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_SETUP,
    FR_LOW,
    FR_HIGH,
    FR_HOLD,
    FR_QUIET
  } fr_state_t;

  localparam logic [1:0] PM_RUN      = 2'b11;
  localparam logic [1:0] PM_OFF_FULL = 2'b10;
  localparam logic [1:0] PM_OFF_AUTO = 2'b01;

endpackage

// File: rtl/adc_seq_tick.sv
module adc_seq_tick #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] word_i,
  input  logic             sample_i,
  input  logic             dout_i,
  output logic             din_o,
  output logic [WIDTH-1:0] rx_o
);

  logic [WIDTH-1:0] tx_q, tx_d;
  logic [WIDTH-1:0] rx_q, rx_d;
  logic             tx_en, rx_en;

  // Both registers move only on a frame start or a rising serial edge.
  assign tx_en = load_i | sample_i;
  assign rx_en = load_i | sample_i;

  always_comb begin
    tx_d = tx_q;
    rx_d = rx_q;
    if (load_i) begin
      tx_d = word_i;
      rx_d = '0;
    end else if (sample_i) begin
      tx_d = {tx_q[WIDTH-2:0], 1'b0};
      rx_d = {rx_q[WIDTH-2:0], dout_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (tx_en) tx_q <= tx_d;
      if (rx_en) rx_q <= rx_d;
    end
  end

  assign din_o = tx_q[WIDTH-1];
  assign rx_o  = rx_q;

endmodule

// File: rtl/adc_seq_frame.sv
module adc_seq_frame
  import adc_seq_pkg::*;
#(
  parameter int unsigned DIV_HALF   = 2,
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned HOLD_CYC   = 2,
  parameter int unsigned QUIET_CYC  = 3,
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned CNT_W      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic start_o,
  output logic sample_o,
  output logic done_o,
  output logic cs_n_o,
  output logic sclk_o
);

  localparam int unsigned BIT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_HALF  = CNT_W'(DIV_HALF - 1);
  localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_QUIET = CNT_W'(QUIET_CYC - 1);

  fr_state_t        state_q, state_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             sclk_q, sclk_d;
  logic             cs_n_q, cs_n_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;

  adc_seq_tick #(.W(CNT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  assign req_ready = (state_q == FR_IDLE);

  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    sclk_d   = sclk_q;
    cs_n_d   = cs_n_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    start_o  = 1'b0;
    sample_o = 1'b0;
    done_o   = 1'b0;
    case (state_q)
      FR_IDLE: begin
        if (req_valid) begin
          cs_n_d   = 1'b0;
          start_o  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = LD_SETUP;
          state_d  = FR_SETUP;
        end
      end
      FR_SETUP: begin
        if (tmr_zero) begin
          sclk_d   = 1'b0;
          bit_d    = '0;
          tmr_load = 1'b1;
          tmr_val  = LD_HALF;
          state_d  = FR_LOW;
        end
      end
      FR_LOW: begin
        if (tmr_zero) begin
          sclk_d   = 1'b1;
          sample_o = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = LD_HALF;
          state_d  = FR_HIGH;
        end
      end
      FR_HIGH: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          if (bit_q == LAST_BIT) begin
            tmr_val = LD_HOLD;
            state_d = FR_HOLD;
          end else begin
            sclk_d  = 1'b0;
            bit_d   = bit_q + 1'b1;
            tmr_val = LD_HALF;
            state_d = FR_LOW;
          end
        end
      end
      FR_HOLD: begin
        if (tmr_zero) begin
          cs_n_d   = 1'b1;
          done_o   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = LD_QUIET;
          state_d  = FR_QUIET;
        end
      end
      FR_QUIET: begin
        if (tmr_zero) begin
          state_d = FR_IDLE;
        end
      end
      default: begin
        state_d = FR_IDLE;
        cs_n_d  = 1'b1;
        sclk_d  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      bit_q   <= '0;
      sclk_q  <= 1'b1;
      cs_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sclk_q  <= sclk_d;
      cs_n_q  <= cs_n_d;
    end
  end

  assign cs_n_o = cs_n_q;
  assign sclk_o = sclk_q;

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> sclk_q) else $error("serial clock low while deselected"); // R2

  AST_SETUP_BEFORE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_q) |-> !$past(cs_n_q)) else $error("clock fell without setup"); // R5

  AST_HOLD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |-> ($past(sclk_q) && $past(bit_q) == LAST_BIT)) else $error("early deselect"); // R6

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_q |-> !req_ready) else $error("ready during frame"); // R7

endmodule

// File: rtl/adc_seq_power.sv
module adc_seq_power
  import adc_seq_pkg::*;
#(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned PU_CYC = 50,
  parameter int unsigned PU_W   = 6,
  parameter int unsigned WR_POS = 11,
  parameter int unsigned PM_POS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] word_i,
  output logic             trust_o
);

  localparam logic [PU_W-1:0] LD_PU = PU_W'(PU_CYC - 1);

  logic [1:0] mode_q, mode_d;
  logic       trust_q, trust_d;
  logic       wr_bit;
  logic [1:0] pm_new;
  logic       wake;
  logic       pu_zero;

  assign wr_bit = word_i[WR_POS];
  assign pm_new = word_i[PM_POS +: 2];
  assign wake   = start_i && wr_bit && (pm_new == PM_RUN) && (mode_q != PM_RUN);

  adc_seq_tick #(.W(PU_W)) u_pwrup (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wake),
    .load_val (LD_PU),
    .zero     (pu_zero)
  );

  always_comb begin
    mode_d  = mode_q;
    trust_d = trust_q;
    if (start_i) begin
      trust_d = (mode_q == PM_RUN) && pu_zero;
      if (wr_bit) mode_d = pm_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= PM_RUN;
      trust_q <= 1'b1;
    end else if (start_i) begin
      mode_q  <= mode_d;
      trust_q <= trust_d;
    end
  end

  assign trust_o = trust_q;

  AST_WAKE_ARMS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (PU_CYC > 1 && wake) |=> !pu_zero) else $error("wake did not arm window"); // R10

  AST_SHUTDOWN_UNTRUSTED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && mode_q != PM_RUN) |=> !trust_o) else $error("trusted in shutdown"); // R9

  AST_NO_WRITE_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !wr_bit) |=> $stable(mode_q)) else $error("mode changed without write"); // R11

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int unsigned DIV_HALF   = 2,
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned HOLD_CYC   = 2,
  parameter int unsigned QUIET_CYC  = 3,
  parameter int unsigned PU_CYC     = 50,
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned WR_POS     = 11,
  parameter int unsigned PM_POS     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [FRAME_BITS-1:0] req_word,
  output logic                  req_ready,
  output logic                  rsp_valid,
  output logic [FRAME_BITS-1:0] rsp_word,
  output logic                  rsp_ok,
  output logic                  adc_cs_n,
  output logic                  adc_sclk,
  output logic                  adc_din,
  input  logic                  adc_dout
);

  localparam int unsigned MAX_A   = (DIV_HALF > SETUP_CYC) ? DIV_HALF : SETUP_CYC;
  localparam int unsigned MAX_B   = (HOLD_CYC > QUIET_CYC) ? HOLD_CYC : QUIET_CYC;
  localparam int unsigned CNT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
  localparam int unsigned PU_W    = (PU_CYC > 1) ? $clog2(PU_CYC) : 1;

  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  logic       start, sample, done;
  logic       rsp_valid_q;

  // Reset asserts at once and leaves two cycles after the pin does.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_i = rst_sync_q[1];

  adc_seq_frame #(
    .DIV_HALF   (DIV_HALF),
    .SETUP_CYC  (SETUP_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .QUIET_CYC  (QUIET_CYC),
    .FRAME_BITS (FRAME_BITS),
    .CNT_W      (CNT_W)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .start_o   (start),
    .sample_o  (sample),
    .done_o    (done),
    .cs_n_o    (adc_cs_n),
    .sclk_o    (adc_sclk)
  );

  adc_seq_shift #(.WIDTH(FRAME_BITS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load_i   (start),
    .word_i   (req_word),
    .sample_i (sample),
    .dout_i   (adc_dout),
    .din_o    (adc_din),
    .rx_o     (rsp_word)
  );

  adc_seq_power #(
    .WIDTH  (FRAME_BITS),
    .PU_CYC (PU_CYC),
    .PU_W   (PU_W),
    .WR_POS (WR_POS),
    .PM_POS (PM_POS)
  ) u_power (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .start_i (start),
    .word_i  (req_word),
    .trust_o (rsp_ok)
  );

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rsp_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= done;
    end
  end
  assign rsp_valid = rsp_valid_q;

  AST_DIN_STABLE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n_i)
    $fell(adc_sclk) |-> $stable(adc_din)) else $error("data-in moved at falling edge"); // R3

  AST_RSP_AT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n_i)
    rsp_valid |-> $rose(adc_cs_n)) else $error("response not aligned to deselect"); // R8

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n_i)
    rsp_valid |=> !rsp_valid) else $error("response longer than one cycle"); // R8

endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;

  localparam int DIV_HALF  = 2;
  localparam int SETUP_CYC = 1;
  localparam int HOLD_CYC  = 2;
  localparam int QUIET_CYC = 3;
  localparam int PU_CYC    = 100;

  typedef struct packed {
    logic [15:0] ctrl;
    logic [15:0] res;
    logic        ok;
  } vec_t;

  // bit 11 = write enable, bits 5:4 = mode (11 run, 10 full off, 01 auto off)
  localparam vec_t VECS [9] = '{
    '{16'h0830, 16'hA5C3, 1'b1},  // normal
    '{16'h0820, 16'h1234, 1'b1},  // enter full shutdown, started in run
    '{16'h0030, 16'hFFFF, 1'b0},  // no write: still shutdown (R11)
    '{16'h0830, 16'h0001, 1'b0},  // wake frame, started in shutdown
    '{16'h0830, 16'h8000, 1'b0},  // inside power-up window (R10)
    '{16'h0830, 16'h7FFE, 1'b1},  // window expired
    '{16'h0810, 16'h5A5A, 1'b1},  // enter auto shutdown
    '{16'h0000, 16'h0F0F, 1'b0},  // auto shutdown active
    '{16'h0830, 16'hF0F0, 1'b0}   // wake from auto
  };

  logic        clk, rst_n;
  logic        req_valid, req_ready, rsp_valid, rsp_ok;
  logic [15:0] req_word, rsp_word;
  logic        cs_n, sclk, din, dout;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  adc_seq_ctrl #(
    .DIV_HALF (DIV_HALF), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC),
    .QUIET_CYC(QUIET_CYC), .PU_CYC(PU_CYC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_word(rsp_word),
    .rsp_ok(rsp_ok), .adc_cs_n(cs_n), .adc_sclk(sclk), .adc_din(din),
    .adc_dout(dout)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // Converter model
  logic [15:0] adc_res, adc_got;
  int falls = 0;
  int frames_seen = 0;
  int setup_run = 0, hold_run = 0, high_run = 0;
  int min_setup = 1000, min_hold = 1000, min_high = 1000;

  initial begin
    dout = 0;
    adc_res = 16'h0;
    adc_got = 16'h0;
  end

  always @(negedge cs_n) begin
    if (frames_seen > 0 && high_run < min_high) min_high = high_run;
    frames_seen++;
    high_run = 0;
    setup_run = 0;
    hold_run = 0;
    falls = 0;
    dout = adc_res[15];
  end

  always @(posedge cs_n) begin
    if (frames_seen > 0) begin
      if (setup_run < min_setup) min_setup = setup_run;
      if (hold_run < min_hold) min_hold = hold_run;
    end
  end

  always @(negedge sclk) begin
    if (!cs_n) begin
      adc_got = {adc_got[14:0], din};
      if (falls < 16) dout = adc_res[15 - falls];
      falls++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n && sclk && falls == 0) setup_run++;
      if (!cs_n && sclk && falls == 16) hold_run++;
      if (cs_n) high_run++;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected completion earlier", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit cond, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    do @(negedge clk); while (!req_ready);
    req_valid = 1'b1;
    req_word  = w;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic frame(input logic [15:0] w, input logic [15:0] res, input logic exp_ok);
    adc_res = res;
    // request raised during the previous quiet gap is held (R7)
    req_valid = 1'b1;
    req_word  = w;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R7 ready low in frame", {31'b0, req_ready}, 32'd0);
    while (!rsp_valid) @(negedge clk);
    check(rsp_word == res, "R4 received word", {16'b0, rsp_word}, {16'b0, res});
    check(adc_got == w, "R3 sent word", {16'b0, adc_got}, {16'b0, w});
    check(falls == 16, "R2 falling edges", falls, 32'd16);
    check(rsp_ok == exp_ok, "R9 R10 trust flag", {31'b0, rsp_ok}, {31'b0, exp_ok});
    check(cs_n == 1'b1, "R8 strobe at deselect", {31'b0, cs_n}, 32'd1);
    check(req_ready == 1'b0, "R7 ready low in gap", {31'b0, req_ready}, 32'd0);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R8 strobe one cycle", {31'b0, rsp_valid}, 32'd0);
  endtask

  initial begin
    rst_n = 0;
    req_valid = 0;
    req_word = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cs_n == 1'b1, "R1 cs idle", {31'b0, cs_n}, 32'd1);
    check(sclk == 1'b1, "R1 sclk idle", {31'b0, sclk}, 32'd1);
    check(rsp_valid == 1'b0, "R1 no response", {31'b0, rsp_valid}, 32'd0);
    check(req_ready == 1'b1, "R1 ready", {31'b0, req_ready}, 32'd1);

    for (int i = 0; i < 9; i++) begin
      frame(VECS[i].ctrl, VECS[i].res, VECS[i].ok);
    end

    // R10: after a long idle the window has expired
    repeat (150) @(negedge clk);
    frame(16'h0830, 16'h3C3C, 1'b1);

    // R11: write bit clear with a shutdown code must not shut down
    frame(16'h0020, 16'hC3C3, 1'b1);
    frame(16'h0830, 16'h0FF0, 1'b1);

    // single spaced request through the plain handshake
    adc_res = 16'h6996;
    send(16'h0830);
    while (!rsp_valid) @(negedge clk);
    check(rsp_word == 16'h6996, "R4 isolated frame", {16'b0, rsp_word}, 32'h6996);
    repeat (10) @(negedge clk);
    check(cs_n == 1'b1 && sclk == 1'b1, "R2 idle after frame", {30'b0, cs_n, sclk}, 32'd3);

    check(min_setup >= SETUP_CYC, "R5 setup cycles", min_setup, SETUP_CYC);
    check(min_hold >= HOLD_CYC, "R6 hold cycles", min_hold, HOLD_CYC);
    check(min_high >= QUIET_CYC + 1, "R7 quiet gap", min_high, QUIET_CYC + 1);

    finished = 1;
    summary();
    $finish;
  end

endmodule